// File: doc/BRIEF.md
# USB Link State Monitor

This block watches the condition of a full-speed USB device link and reports which phase the link is in. It runs on the 48 MHz device clock and consumes already-decoded line information: whether the line shows single-ended zero, whether it shows the idle (J) symbol, a strobe for each valid start-of-frame token with its frame index, the VBUS sense level and the device's own pull-up enable. From these it runs a seven-state link machine with three hold timers. The timers detect bus reset (long SE0), suspend (long idle) and loss of the host (no start-of-frame on an active link).

Outputs are a 3-bit link state code, a host-lost flag, the latched frame index, the device address and a set of one-cycle event strobes. Firmware may load the device address, which the block zeroes on every bus reset. It may also issue a resume command so that a freshly powered link proceeds as if resuming. A link that suspends before its first bus reset takes a separate suspend state, so the link is never treated as configured when it was never reset.

Top module: `usb_link_monitor`

## Requirements
- R1: Link state codes are 0 detached, 1 powered, 2 powered-and-suspended (never reset), 3 running, 4 suspended after running, 5 running with no frame token yet, 6 resuming. After reset the state is 0, every event strobe and the host-lost flag are 0, and the frame index and address are 0. No other code ever appears.
- R2: When VBUS sense or the pull-up enable is low, the state becomes 0 on the next cycle. The disconnected strobe pulses for one cycle when this leaves a nonzero state. With both high, state 0 moves to 1 on the next edge.
- R3: A rising edge on VBUS sense pulses the powered strobe for one cycle, whether or not the pull-up is enabled.
- R4: SE0 held for RST_CYC consecutive cycles moves any connected state to 5 and pulses the reset strobe on that edge. A shorter SE0 run has no effect, and an interruption restarts the count.
- R5: An address write loads the address output on the next edge. A detected bus reset clears it to 0.
- R6: Idle held for SUSP_CYC consecutive cycles moves state 1 to 2, and states 3 and 5 to 4. Each of these moves pulses the suspend strobe.
- R7: Any non-idle line cycle moves state 2 back to 1, and state 4 to 6. Each of these moves pulses the resume strobe. In state 6, the end-of-resume input moves the link to 3.
- R8: The resume command moves state 1 to 6. In every other state it has no effect.
- R9: Each frame token received while connected latches the 11-bit frame index and pulses the frame strobe. In state 5, it moves the link to 3.
- R10: In state 3, LOST_CYC consecutive cycles without a frame token set the host-lost flag and pulse the host-lost strobe. The next frame token, or leaving state 3, clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 48 MHz device clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vbus_sense_i | input | 1 | Host is supplying VBUS |
| pullup_en_i | input | 1 | Device pull-up is enabled |
| line_se0_i | input | 1 | Line currently shows single-ended zero |
| line_idle_i | input | 1 | Line currently shows the idle (J) symbol |
| sof_valid_i | input | 1 | One-cycle strobe for a valid start-of-frame token |
| sof_frame_i | input | FRAME_W | Frame index carried by that token |
| resume_cmd_i | input | 1 | Firmware resume command |
| resume_done_i | input | 1 | End of resume signalling observed |
| addr_we_i | input | 1 | Load the device address |
| addr_i | input | ADDR_W | Device address to load |
| link_state_o | output | 3 | Encoded link state |
| host_lost_o | output | 1 | Frame tokens missing on an active link |
| frame_num_o | output | FRAME_W | Last latched frame index |
| dev_addr_o | output | ADDR_W | Current device address |
| ev_disconnected_o | output | 1 | Link dropped to detached |
| ev_powered_o | output | 1 | VBUS appeared |
| ev_reset_o | output | 1 | Bus reset detected |
| ev_suspend_o | output | 1 | Link entered a suspend state |
| ev_resume_o | output | 1 | Link left a suspend state |
| ev_frame_o | output | 1 | Frame index updated |
| ev_host_lost_o | output | 1 | Host-lost flag just set |

## Verification
Every output is registered, so a stimulus sampled at a rising edge shows up at the outputs right after that edge. A timed condition lands on exactly the Nth consecutive edge at which its input is held, with N being RST_CYC, SUSP_CYC or LOST_CYC. The bench changes inputs at falling edges and holds them for a counted number of rising edges. It then samples state, strobes and flags at the following falling edge, so a one-cycle strobe is seen in exactly the cycle it is due. The timer limits are shortened, and each timer is also run for one cycle less than its limit to show that nothing fires early.

// File: rtl/usb_link_pkg.sv
`timescale 1ns/1ps
package usb_link_pkg;

   typedef enum logic [2:0] {
      LS_OFF       = 3'd0,
      LS_PWR       = 3'd1,
      LS_PWR_SLEEP = 3'd2,
      LS_RUN       = 3'd3,
      LS_SLEEP     = 3'd4,
      LS_RUN_NOSOF = 3'd5,
      LS_WAKING    = 3'd6
   } link_st_e;

   function automatic logic is_asleep(link_st_e s);
      return (s == LS_PWR_SLEEP) || (s == LS_SLEEP);
   endfunction

endpackage

// File: rtl/ulm_hold_timer.sv
`timescale 1ns/1ps
// Counts consecutive cycles of cond; hit is high on the LIMIT-th one only.
module ulm_hold_timer #(
   parameter int unsigned LIMIT = 144
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic cond_i,
   output logic hit_o
);
   localparam int unsigned CW = $clog2(LIMIT + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           cnt_q <= '0;
      else if (!cond_i)                      cnt_q <= '0;
      else if (cnt_q != CW'(LIMIT))          cnt_q <= cnt_q + 1'b1;
   end

   assign hit_o = cond_i && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/ulm_link_fsm.sv
`timescale 1ns/1ps
module ulm_link_fsm
   import usb_link_pkg::*;
(
   input  logic     clk_i,
   input  logic     rst_ni,
   input  logic     conn_i,
   input  logic     se0_hit_i,
   input  logic     idle_hit_i,
   input  logic     line_idle_i,
   input  logic     sof_i,
   input  logic     resume_cmd_i,
   input  logic     resume_done_i,
   output link_st_e state_o,
   output logic     ev_disc_o,
   output logic     ev_reset_o,
   output logic     ev_susp_o,
   output logic     ev_resume_o
);
   link_st_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      if (!conn_i) begin
         st_d = LS_OFF;
      end else begin
         unique case (st_q)
            LS_OFF:       st_d = LS_PWR;
            LS_PWR: begin
               if (se0_hit_i)         st_d = LS_RUN_NOSOF;
               else if (resume_cmd_i) st_d = LS_WAKING;
               else if (idle_hit_i)   st_d = LS_PWR_SLEEP;
            end
            LS_PWR_SLEEP: begin
               if (se0_hit_i)         st_d = LS_RUN_NOSOF;
               else if (!line_idle_i) st_d = LS_PWR;
            end
            LS_RUN_NOSOF: begin
               if (se0_hit_i)         st_d = LS_RUN_NOSOF;
               else if (sof_i)        st_d = LS_RUN;
               else if (idle_hit_i)   st_d = LS_SLEEP;
            end
            LS_RUN: begin
               if (se0_hit_i)         st_d = LS_RUN_NOSOF;
               else if (idle_hit_i)   st_d = LS_SLEEP;
            end
            LS_SLEEP: begin
               if (se0_hit_i)         st_d = LS_RUN_NOSOF;
               else if (!line_idle_i) st_d = LS_WAKING;
            end
            LS_WAKING: begin
               if (se0_hit_i)          st_d = LS_RUN_NOSOF;
               else if (resume_done_i) st_d = LS_RUN;
            end
            default:                   st_d = LS_OFF;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q        <= LS_OFF;
         ev_disc_o   <= 1'b0;
         ev_reset_o  <= 1'b0;
         ev_susp_o   <= 1'b0;
         ev_resume_o <= 1'b0;
      end else begin
         st_q        <= st_d;
         ev_disc_o   <= !conn_i && (st_q != LS_OFF);
         ev_reset_o  <= conn_i && se0_hit_i;
         ev_susp_o   <= conn_i && is_asleep(st_d) && !is_asleep(st_q);
         ev_resume_o <= conn_i && is_asleep(st_q) && !is_asleep(st_d);
      end
   end

   assign state_o = st_q;
endmodule

// File: rtl/usb_link_monitor.sv
`timescale 1ns/1ps
module usb_link_monitor
   import usb_link_pkg::*;
#(
   parameter int unsigned RST_CYC  = 144,
   parameter int unsigned SUSP_CYC = 144000,
   parameter int unsigned LOST_CYC = 196608,
   parameter int unsigned FRAME_W  = 11,
   parameter int unsigned ADDR_W   = 7,
   parameter bit          LOST_EN  = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               vbus_sense_i,
   input  logic               pullup_en_i,
   input  logic               line_se0_i,
   input  logic               line_idle_i,
   input  logic               sof_valid_i,
   input  logic [FRAME_W-1:0] sof_frame_i,
   input  logic               resume_cmd_i,
   input  logic               resume_done_i,
   input  logic               addr_we_i,
   input  logic [ADDR_W-1:0]  addr_i,
   output logic [2:0]         link_state_o,
   output logic               host_lost_o,
   output logic [FRAME_W-1:0] frame_num_o,
   output logic [ADDR_W-1:0]  dev_addr_o,
   output logic               ev_disconnected_o,
   output logic               ev_powered_o,
   output logic               ev_reset_o,
   output logic               ev_suspend_o,
   output logic               ev_resume_o,
   output logic               ev_frame_o,
   output logic               ev_host_lost_o
);
   initial begin : p_param_check
      assert (RST_CYC >= 2)         else $fatal(1, "RST_CYC too small");
      assert (SUSP_CYC > RST_CYC)   else $fatal(1, "SUSP_CYC must exceed RST_CYC");
      assert (LOST_CYC >= 2)        else $fatal(1, "LOST_CYC too small");
      assert (FRAME_W >= 1 && ADDR_W >= 1) else $fatal(1, "bad field widths");
   end

   logic     conn, se0_hit, idle_hit, lost_hit, vbus_q;
   link_st_e st;

   assign conn = vbus_sense_i && pullup_en_i;

   ulm_hold_timer #(.LIMIT(RST_CYC)) u_se0_tmr (
      .clk_i, .rst_ni, .cond_i(line_se0_i), .hit_o(se0_hit));

   ulm_hold_timer #(.LIMIT(SUSP_CYC)) u_idle_tmr (
      .clk_i, .rst_ni, .cond_i(line_idle_i), .hit_o(idle_hit));

   generate
      if (LOST_EN) begin : g_lost
         ulm_hold_timer #(.LIMIT(LOST_CYC)) u_lost_tmr (
            .clk_i, .rst_ni,
            .cond_i(conn && (st == LS_RUN) && !sof_valid_i),
            .hit_o(lost_hit));
      end else begin : g_nolost
         assign lost_hit = 1'b0;
      end
   endgenerate

   ulm_link_fsm u_fsm (
      .clk_i, .rst_ni,
      .conn_i        (conn),
      .se0_hit_i     (se0_hit),
      .idle_hit_i    (idle_hit),
      .line_idle_i   (line_idle_i),
      .sof_i         (sof_valid_i),
      .resume_cmd_i  (resume_cmd_i),
      .resume_done_i (resume_done_i),
      .state_o       (st),
      .ev_disc_o     (ev_disconnected_o),
      .ev_reset_o    (ev_reset_o),
      .ev_susp_o     (ev_suspend_o),
      .ev_resume_o   (ev_resume_o));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         vbus_q         <= 1'b0;
         ev_powered_o   <= 1'b0;
         frame_num_o    <= '0;
         ev_frame_o     <= 1'b0;
         dev_addr_o     <= '0;
         host_lost_o    <= 1'b0;
         ev_host_lost_o <= 1'b0;
      end else begin
         vbus_q         <= vbus_sense_i;
         ev_powered_o   <= vbus_sense_i && !vbus_q;
         ev_frame_o     <= conn && sof_valid_i;
         if (conn && sof_valid_i) frame_num_o <= sof_frame_i;
         if (conn && se0_hit)     dev_addr_o <= '0;
         else if (addr_we_i)      dev_addr_o <= addr_i;
         ev_host_lost_o <= lost_hit;
         if (lost_hit)                                host_lost_o <= 1'b1;
         else if (sof_valid_i || st != LS_RUN || !conn) host_lost_o <= 1'b0;
      end
   end

   assign link_state_o = st;
endmodule

// File: rtl/usb_link_monitor_chk.sv
`timescale 1ns/1ps
module usb_link_monitor_chk #(
   parameter int unsigned FRAME_W = 11,
   parameter int unsigned ADDR_W  = 7
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               vbus_sense_i,
   input logic               pullup_en_i,
   input logic               resume_cmd_i,
   input logic [FRAME_W-1:0] sof_frame_i,
   input logic [2:0]         link_state_o,
   input logic               host_lost_o,
   input logic [FRAME_W-1:0] frame_num_o,
   input logic [ADDR_W-1:0]  dev_addr_o,
   input logic               ev_reset_o,
   input logic               ev_suspend_o,
   input logic               ev_resume_o,
   input logic               ev_frame_o,
   input logic               ev_host_lost_o
);
   assert_legal_code_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      link_state_o != 3'd7);

   assert_detach_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(vbus_sense_i && pullup_en_i) |=> link_state_o == 3'd0);

   assert_reset_target_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_reset_o |-> link_state_o == 3'd5);

   assert_addr_cleared_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_reset_o |-> dev_addr_o == '0);

   assert_suspend_target_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_suspend_o |-> (link_state_o == 3'd2 || link_state_o == 3'd4));

   assert_resume_source_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_resume_o |-> ($past(link_state_o) == 3'd2 || $past(link_state_o) == 3'd4));

   assert_waking_entry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (link_state_o == 3'd6 && $past(link_state_o) != 3'd6) |->
      ($past(link_state_o) == 3'd4 || ($past(link_state_o) == 3'd1 && $past(resume_cmd_i))));

   assert_frame_latch_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_frame_o |-> frame_num_o == $past(sof_frame_i));

   assert_lost_only_running_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(host_lost_o) |-> (ev_host_lost_o && $past(link_state_o) == 3'd3));
endmodule

bind usb_link_monitor usb_link_monitor_chk #(.FRAME_W(FRAME_W), .ADDR_W(ADDR_W)) u_chk (
   .clk_i, .rst_ni, .vbus_sense_i, .pullup_en_i, .resume_cmd_i, .sof_frame_i,
   .link_state_o, .host_lost_o, .frame_num_o, .dev_addr_o,
   .ev_reset_o, .ev_suspend_o, .ev_resume_o, .ev_frame_o, .ev_host_lost_o);

// File: tb/usb_link_monitor_bench.sv
`timescale 1ns/1ps
module usb_link_monitor_bench;
   localparam int unsigned RST  = 8;
   localparam int unsigned SUSP = 40;
   localparam int unsigned LOST = 60;

   // event vector order: disc, powered, reset, suspend, resume, frame, host_lost
   localparam logic [6:0] E0 = 7'b0000000, ED = 7'b1000000, EP = 7'b0100000,
                          ER = 7'b0010000, ES = 7'b0001000, EM = 7'b0000100,
                          EF = 7'b0000010, EL = 7'b0000001;

   typedef struct packed {
      logic [7:0]  n;
      logic        vbus, pu, se0, idle, sof;
      logic [10:0] fr;
      logic        cmd, rdone;
      logic [2:0]  st;
      logic [6:0]  ev;
      logic        hl;
      logic [10:0] xfr;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t TBL [NV] = '{
      '{8'd1,  1,0,0,0,0, 11'h000, 0,0, 3'd0, EP, 0, 11'h000, 4'd3},  // R3 vbus rise
      '{8'd1,  1,1,0,0,0, 11'h000, 0,0, 3'd1, E0, 0, 11'h000, 4'd2},  // R2 attach
      '{SUSP,  1,1,0,1,0, 11'h000, 0,0, 3'd2, ES, 0, 11'h000, 4'd6},  // R6 never-reset suspend
      '{8'd1,  1,1,0,0,0, 11'h000, 0,0, 3'd1, EM, 0, 11'h000, 4'd7},  // R7 back to powered
      '{RST-1, 1,1,1,0,0, 11'h000, 0,0, 3'd1, E0, 0, 11'h000, 4'd4},  // R4 short SE0
      '{8'd1,  1,1,0,0,0, 11'h000, 0,0, 3'd1, E0, 0, 11'h000, 4'd4},  // R4 interrupted
      '{RST,   1,1,1,0,0, 11'h000, 0,0, 3'd5, ER, 0, 11'h000, 4'd4},  // R4 full SE0
      '{8'd1,  1,1,0,0,1, 11'h123, 0,0, 3'd3, EF, 0, 11'h123, 4'd9},  // R9 first frame
      '{LOST-1,1,1,0,0,0, 11'h123, 0,0, 3'd3, E0, 0, 11'h123, 4'd10}, // R10 not yet
      '{8'd1,  1,1,0,0,0, 11'h123, 0,0, 3'd3, EL, 1, 11'h123, 4'd10}, // R10 lost
      '{8'd1,  1,1,0,0,1, 11'h7FF, 0,0, 3'd3, EF, 0, 11'h7FF, 4'd10}, // R10 cleared, R9
      '{SUSP,  1,1,0,1,0, 11'h7FF, 0,0, 3'd4, ES, 0, 11'h7FF, 4'd6},  // R6 suspend
      '{8'd1,  1,1,0,0,0, 11'h7FF, 0,0, 3'd6, EM, 0, 11'h7FF, 4'd7},  // R7 resuming
      '{8'd1,  1,1,0,0,0, 11'h7FF, 0,1, 3'd3, E0, 0, 11'h7FF, 4'd7},  // R7 resume end
      '{8'd1,  0,1,0,0,0, 11'h7FF, 0,0, 3'd0, ED, 0, 11'h7FF, 4'd2},  // R2 vbus lost
      '{8'd1,  1,1,0,0,0, 11'h7FF, 0,0, 3'd1, EP, 0, 11'h7FF, 4'd3},  // R3 vbus back
      '{8'd1,  1,1,0,0,0, 11'h7FF, 1,0, 3'd6, E0, 0, 11'h7FF, 4'd8},  // R8 accepted
      '{8'd1,  1,1,0,0,0, 11'h7FF, 1,0, 3'd6, E0, 0, 11'h7FF, 4'd8},  // R8 no effect
      '{8'd1,  1,1,0,0,0, 11'h7FF, 0,1, 3'd3, E0, 0, 11'h7FF, 4'd7},  // R7
      '{8'd1,  1,1,0,0,0, 11'h7FF, 1,0, 3'd3, E0, 0, 11'h7FF, 4'd8},  // R8 ignored
      '{8'd1,  1,0,0,0,0, 11'h7FF, 0,0, 3'd0, ED, 0, 11'h7FF, 4'd2}   // R2 pull-up off
   };

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        vbus = 0, pu = 0, se0 = 0, idle = 0, sof = 0, cmd = 0, rdone = 0, awe = 0;
   logic [10:0] fr = '0;
   logic [6:0]  addr = '0;
   logic [2:0]  st;
   logic        hl;
   logic [10:0] frame;
   logic [6:0]  dev_addr;
   logic        e_d, e_p, e_r, e_s, e_m, e_f, e_l;
   int          checks = 0, errors = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;  // 100 MHz

   usb_link_monitor #(.RST_CYC(RST), .SUSP_CYC(SUSP), .LOST_CYC(LOST)) u_usb_link_monitor (
      .clk_i(clk), .rst_ni(rst_n), .vbus_sense_i(vbus), .pullup_en_i(pu),
      .line_se0_i(se0), .line_idle_i(idle), .sof_valid_i(sof), .sof_frame_i(fr),
      .resume_cmd_i(cmd), .resume_done_i(rdone), .addr_we_i(awe), .addr_i(addr),
      .link_state_o(st), .host_lost_o(hl), .frame_num_o(frame), .dev_addr_o(dev_addr),
      .ev_disconnected_o(e_d), .ev_powered_o(e_p), .ev_reset_o(e_r), .ev_suspend_o(e_s),
      .ev_resume_o(e_m), .ev_frame_o(e_f), .ev_host_lost_o(e_l));

   task automatic check(input string what, input int rq, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL R%0d %s: actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic hold(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("reset state", 1, st, 0);
      check("reset events", 1, {e_d, e_p, e_r, e_s, e_m, e_f, e_l}, 0);
      check("reset host_lost", 1, hl, 0);
      check("reset frame/addr", 1, {frame, dev_addr}, 0);

      for (int i = 0; i < NV; i++) begin
         vbus = TBL[i].vbus; pu = TBL[i].pu; se0 = TBL[i].se0; idle = TBL[i].idle;
         sof = TBL[i].sof; fr = TBL[i].fr; cmd = TBL[i].cmd; rdone = TBL[i].rdone;
         hold(int'(TBL[i].n));
         check($sformatf("row %0d state", i), int'(TBL[i].rq), st, TBL[i].st);
         check($sformatf("row %0d events", i), int'(TBL[i].rq),
               {e_d, e_p, e_r, e_s, e_m, e_f, e_l}, TBL[i].ev);
         check($sformatf("row %0d host_lost", i), int'(TBL[i].rq), hl, TBL[i].hl);
         check($sformatf("row %0d frame", i), int'(TBL[i].rq), frame, TBL[i].xfr);
      end
      cmd = 0; rdone = 0; sof = 0;

      // R5 address load, then cleared by bus reset
      awe = 1; addr = 7'h2A;
      hold(1);
      awe = 0;
      check("address load", 5, dev_addr, 7'h2A);
      pu = 1;
      hold(1);
      check("reattach", 2, st, 1);
      se0 = 1;
      hold(RST);
      se0 = 0;
      check("address cleared by reset", 5, dev_addr, 0);
      check("reset from powered", 4, st, 5);

      // R6 suspend before first frame token goes to suspended after running
      idle = 1;
      hold(SUSP);
      check("nosof suspend state", 6, st, 4);
      check("nosof suspend event", 6, e_s, 1);
      hold(1);
      check("suspend strobe one cycle", 6, e_s, 0);

      // R9 frame token while detached is not latched
      pu = 0; idle = 0;
      hold(1);
      sof = 1; fr = 11'h055;
      hold(1);
      sof = 0;
      check("frame ignored when detached", 9, {e_f, frame}, {1'b0, 11'h7FF});

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R1 watchdog: actual=timeout expected=completion");
         summary();
         $finish;
      end
   end
endmodule